// File: doc/BRIEF.md
# Dual-Clock Frequency Meter

The block measures an unknown clock against a known one. Software programs a window length N as a count of reference-clock periods, enables the block and issues a start command. The reference domain then holds a gate open for exactly N of its periods. While the gate is open, the measured-clock domain counts its own rising edges. When the gate closes, the count is handed back to the bus domain, latched into a result register, and a completion flag is raised. Software derives the frequency as result × f_ref ÷ N.

Three clocks are involved: the bus clock, the reference clock and the measured clock. No timing relationship between them is assumed. Every control event crosses between domains through two-flop synchronizers, either as a toggle or as a slow level. The count itself is read across the boundary only after the measured domain has reported that it has stopped counting. A narrow counter that wraps marks the wrap in a sticky status bit. A maskable interrupt signals completion.

Top module: `freq_meter`

## Requirements
- R1: After reset, CTRL, the interrupt enable, FLAG, STAT, SYNC and RESULT all read 0 and irq_o is 0. CFG reads 1.
- R2: CTRL (address 0) bit 0 is the enable and reads back as written. After a change, SYNC (address 7) bit 0 reads 1 until the new value has reached both clock domains and come back, and then returns to 0.
- R3: Writing 1 to bit 0 of CMD (address 1) starts a measurement when the block is enabled, idle and SYNC is 0. STAT (address 6) bit 0 (busy) reads 1 from the next cycle. CMD always reads 0.
- R4: CFG (address 2) bits 7:0 hold the window length N. The window lasts N reference periods, and N = 0 acts as 1. RESULT (address 8) then holds the number of measured rising edges, which is floor or ceil of N·T_ref/T_msr, taken modulo 2^CNT_W and zero-extended to 32 bits.
- R5: At the end of a measurement, FLAG (address 5) bit 0 is set and busy clears in the same cycle. Writing 1 to FLAG bit 0 clears the flag.
- R6: STAT bit 1 sets when the CNT_W-bit edge counter wraps during a measurement. It stays set through later measurements until 1 is written to STAT bit 1.
- R7: A CMD start is ignored while the block is disabled, busy, or has SYNC pending. No measurement begins and no completion follows.
- R8: Writing 1 to bit 0 of IEN_SET (address 3) enables the done interrupt. Writing 1 to bit 0 of IEN_CLR (address 4) disables it. Both addresses read the enable state in bit 0.
- R9: irq_o is 1 exactly when the done flag and the done interrupt enable are both set.
- R10: A write to CFG while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, all domains |
| ref_clk_i | input | 1 | Reference clock defining the gate window |
| msr_clk_i | input | 1 | Clock being measured |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Done interrupt |

## Verification
The properties assume that each bus access is a one-cycle strobe. They also assume that the enable is not withdrawn while a measurement is in flight, because a start that is lost across domains would leave busy set. The stimulus waits for SYNC to clear before it issues a start. It never disables the block mid-window, and it changes the measured clock period only between measurements. Both foreign clocks run free and are offset from the bus clock, so expected counts are exactly floor or ceil of the period ratio, including the cases that wrap the counter.

// File: rtl/freq_meter_pkg.sv
`timescale 1ns/1ps
package freq_meter_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_CMD     = 4'd1,
    A_CFG     = 4'd2,
    A_IEN_SET = 4'd3,
    A_IEN_CLR = 4'd4,
    A_FLAG    = 4'd5,
    A_STAT    = 4'd6,
    A_SYNC    = 4'd7,
    A_RESULT  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fm_ref_gate.sv
`timescale 1ns/1ps
module fm_ref_gate #(
  parameter int REF_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             start_tgl_i,
  input  logic             en_i,
  input  logic [REF_W-1:0] ref_num_i,
  output logic             gate_o,
  output logic             en_echo_o
);
  logic start_s, en_s, start_seen_q, gate_q;
  logic [REF_W-1:0] rem_q;

  fm_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, start_tgl_i}),
    .q_o   ({en_s, start_s})
  );

  // ref_num_i is held static by the bus side while busy
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_seen_q <= 1'b0;
      gate_q       <= 1'b0;
      rem_q        <= '0;
    end else begin
      start_seen_q <= start_s;
      if (gate_q) begin
        if (!en_s || rem_q <= REF_W'(1)) gate_q <= 1'b0;
        else                             rem_q  <= rem_q - REF_W'(1);
      end else if ((start_s ^ start_seen_q) && en_s) begin
        gate_q <= 1'b1;
        rem_q  <= ref_num_i;
      end
    end
  end

  assign gate_o    = gate_q;
  assign en_echo_o = en_s;
endmodule

// File: rtl/fm_msr_count.sv
`timescale 1ns/1ps
module fm_msr_count #(
  parameter int CNT_W  = 24,
  parameter int STAGES = 2
) (
  input  logic             msr_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             done_tgl_o,
  output logic             en_echo_o
);
  logic gate_s, en_s, gate_d_q, wrap_q, done_tgl_q;
  logic [CNT_W-1:0] cnt_q;

  fm_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk_i (msr_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, gate_i}),
    .q_o   ({en_s, gate_s})
  );

  always_ff @(posedge msr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d_q   <= 1'b0;
      cnt_q      <= '0;
      wrap_q     <= 1'b0;
      done_tgl_q <= 1'b0;
    end else begin
      gate_d_q <= gate_s;
      if (gate_s && !gate_d_q) begin
        cnt_q  <= CNT_W'(1);
        wrap_q <= 1'b0;
      end else if (gate_s) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (&cnt_q) wrap_q <= 1'b1;
      end
      // count is frozen from here until the next window opens
      if (!gate_s && gate_d_q) done_tgl_q <= ~done_tgl_q;
    end
  end

  assign cnt_o      = cnt_q;
  assign wrap_o     = wrap_q;
  assign done_tgl_o = done_tgl_q;
  assign en_echo_o  = en_s;
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int REF_W  = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              msr_clk_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [REF_W-1:0] CFG_RST = REF_W'(1);

  logic en_q, busy_q, done_q, ovf_q, ien_q, start_tgl_q, done_seen_q;
  logic [REF_W-1:0]  ref_num_q;
  logic [DATA_W-1:0] result_q;

  logic gate, en_ref_echo, en_msr_echo, wrap, done_tgl;
  logic [CNT_W-1:0] msr_cnt;
  logic en_ref_b, en_msr_b, done_s;
  logic wr, sync_pend, cmd_go, done_ev;

  fm_ref_gate #(.REF_W(REF_W), .STAGES(STAGES)) u_ref_gate (
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .start_tgl_i(start_tgl_q),
    .en_i       (en_q),
    .ref_num_i  (ref_num_q),
    .gate_o     (gate),
    .en_echo_o  (en_ref_echo)
  );

  fm_msr_count #(.CNT_W(CNT_W), .STAGES(STAGES)) u_msr_count (
    .msr_clk_i (msr_clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate),
    .en_i      (en_q),
    .cnt_o     (msr_cnt),
    .wrap_o    (wrap),
    .done_tgl_o(done_tgl),
    .en_echo_o (en_msr_echo)
  );

  fm_sync #(.W(3), .STAGES(STAGES)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_ref_echo, en_msr_echo, done_tgl}),
    .q_o   ({en_ref_b, en_msr_b, done_s})
  );

  assign wr        = req_i && we_i;
  assign sync_pend = (en_q != en_ref_b) || (en_q != en_msr_b);
  assign cmd_go    = wr && addr_i == A_CMD && wdata_i[0] && en_q && !busy_q && !sync_pend;
  assign done_ev   = done_s ^ done_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      ovf_q       <= 1'b0;
      ien_q       <= 1'b0;
      start_tgl_q <= 1'b0;
      done_seen_q <= 1'b0;
      ref_num_q   <= CFG_RST;
      result_q    <= '0;
    end else begin
      done_seen_q <= done_s;
      if (wr && addr_i == A_CTRL) en_q <= wdata_i[0];
      if (wr && addr_i == A_CFG && !busy_q) ref_num_q <= wdata_i[REF_W-1:0];

      if (wr && addr_i == A_IEN_SET && wdata_i[0])      ien_q <= 1'b1;
      else if (wr && addr_i == A_IEN_CLR && wdata_i[0]) ien_q <= 1'b0;

      if (cmd_go) begin
        start_tgl_q <= ~start_tgl_q;
        busy_q      <= 1'b1;
      end else if (done_ev) begin
        busy_q <= 1'b0;
      end

      // hardware set wins over software clear
      if (done_ev)                                  done_q <= 1'b1;
      else if (wr && addr_i == A_FLAG && wdata_i[0]) done_q <= 1'b0;

      if (done_ev && wrap)                           ovf_q <= 1'b1;
      else if (wr && addr_i == A_STAT && wdata_i[1]) ovf_q <= 1'b0;

      // msr_cnt is static once done_tgl has been seen here
      if (done_ev) result_q <= DATA_W'(msr_cnt);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:               rdata_o[0] = en_q;
      A_CFG:                rdata_o[REF_W-1:0] = ref_num_q;
      A_IEN_SET, A_IEN_CLR: rdata_o[0] = ien_q;
      A_FLAG:               rdata_o[0] = done_q;
      A_STAT:               rdata_o[1:0] = {ovf_q, busy_q};
      A_SYNC:               rdata_o[0] = sync_pend;
      A_RESULT:             rdata_o = result_q;
      default:              rdata_o = '0;
    endcase
  end

  assign irq_o = done_q && ien_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:REF_W];
endmodule

// File: rtl/freq_meter_chk.sv
`timescale 1ns/1ps
module freq_meter_chk
  import freq_meter_pkg::*;
#(
  parameter int REF_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              en_q,
  input logic              busy_q,
  input logic              done_q,
  input logic              ovf_q,
  input logic              ien_q,
  input logic              start_tgl_q,
  input logic              sync_pend,
  input logic [REF_W-1:0]  ref_num_q
);
  logic wr_cmd, wr_cfg, wr_stat1, wr_iclr, wr_iset;
  assign wr_cmd   = req_i && we_i && addr_i == A_CMD && wdata_i[0];
  assign wr_cfg   = req_i && we_i && addr_i == A_CFG;
  assign wr_stat1 = req_i && we_i && addr_i == A_STAT && wdata_i[1];
  assign wr_iclr  = req_i && we_i && addr_i == A_IEN_CLR && wdata_i[0];
  assign wr_iset  = req_i && we_i && addr_i == A_IEN_SET && wdata_i[0] && !wr_iclr;

  // R3
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd && en_q && !busy_q && !sync_pend |=> busy_q && start_tgl_q != $past(start_tgl_q));

  // R7
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd && (busy_q || !en_q || sync_pend) |=> $stable(start_tgl_q));

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg && busy_q |=> $stable(ref_num_q));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !wr_stat1 |=> ovf_q);

  // R5
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !busy_q);

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_iclr |=> !irq_o);

  // R8
  ien_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_iset |=> ien_q);
endmodule

bind freq_meter freq_meter_chk #(.REF_W(REF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .en_q       (en_q),
  .busy_q     (busy_q),
  .done_q     (done_q),
  .ovf_q      (ovf_q),
  .ien_q      (ien_q),
  .start_tgl_q(start_tgl_q),
  .sync_pend  (sync_pend),
  .ref_num_q  (ref_num_q)
);

// File: tb/tb_freq_meter.sv
`timescale 1ns/1ps
module tb_freq_meter;
  localparam int CNT_W  = 8;
  localparam int MOD    = 1 << CNT_W;
  localparam int T_REF  = 40;

  logic clk = 0, ref_clk = 0, msr_clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int msr_half = 3;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  initial begin #1; forever #(T_REF/2) ref_clk = ~ref_clk; end
  initial begin #3; forever #(msr_half) msr_clk = ~msr_clk; end

  freq_meter #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .msr_clk_i(msr_clk),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); req = 1; we = 1; addr = 4'(a); wdata = 32'(d);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); addr = 4'(a); #1; d = int'(rdata);
  endtask

  task automatic wait_bit(int a, int b, int val, int lim, output bit ok);
    int d;
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      rd(a, d);
      if (((d >> b) & 1) == val) begin ok = 1; break; end
    end
  endtask

  task automatic measure(int n, int half, bit clr_ovf);
    int d, p, lo, nn;
    bit ok;
    msr_half = half;
    p = 2 * half;
    nn = (n == 0) ? 1 : n;
    wr(2, n);
    wr(5, 1);
    if (clr_ovf) wr(6, 2);
    wr(1, 1);
    rd(6, d); chk("R3 busy after start", d & 1, 1);
    rd(1, d); chk("R3 cmd reads 0", d, 0);
    wr(2, 99);
    rd(2, d); chk("R10 cfg held while busy", d, n);
    wait_bit(5, 0, 1, 8000, ok);
    chk("R5 done flag set", int'(ok), 1);
    rd(6, d); chk("R5 busy cleared", d & 1, 0);
    rd(8, d);
    lo = (nn * T_REF) / p;
    checks++;
    if (d != lo % MOD && d != (lo + 1) % MOD) begin
      failures++;
      $display("FAIL R4 n=%0d p=%0d act=%0d exp=%0d..%0d", n, p, d, lo % MOD, (lo + 1) % MOD);
    end
    if (clr_ovf) begin
      rd(6, d);
      if (lo >= MOD)          chk("R6 ovf set on wrap", (d >> 1) & 1, 1);
      else if (lo + 1 < MOD)  chk("R6 ovf clear, no wrap", (d >> 1) & 1, 0);
    end
  endtask

  initial begin
    int d;
    bit ok;
    int halves[4] = '{3, 5, 9, 17};
    int ns[7] = '{1, 2, 7, 38, 64, 130, 255};
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(2, d); chk("R1 cfg", d, 1);
    rd(3, d); chk("R1 ien", d, 0);
    rd(5, d); chk("R1 flag", d, 0);
    rd(6, d); chk("R1 stat", d, 0);
    rd(7, d); chk("R1 sync", d, 0);
    rd(8, d); chk("R1 result", d, 0);
    chk("R1 irq", int'(irq), 0);
    // R7 start while disabled
    wr(1, 1);
    rd(6, d); chk("R7 disabled start busy", d & 1, 0);
    repeat (200) @(negedge clk);
    rd(5, d); chk("R7 disabled start no done", d, 0);
    // R2
    wr(0, 1);
    rd(7, d); chk("R2 sync pending", d & 1, 1);
    wr(1, 1);
    rd(6, d); chk("R7 start during sync pending", d & 1, 0);
    rd(0, d); chk("R2 ctrl readback", d, 1);
    wait_bit(7, 0, 0, 200, ok); chk("R2 sync clears", int'(ok), 1);
    repeat (400) @(negedge clk);
    rd(5, d); chk("R7 pending start no done", d, 0);
    // R8
    wr(3, 1);
    rd(3, d); chk("R8 ien set", d & 1, 1);
    rd(4, d); chk("R8 ien via clr addr", d & 1, 1);
    // sweep
    for (int h = 0; h < 4; h++)
      for (int k = 0; k < 7; k++) begin
        measure(ns[k], halves[h], 1);
        chk("R9 irq with flag and enable", int'(irq), 1);
      end
    // R9 / R8 / R5 mask and clear
    wr(4, 1);
    chk("R9 irq masked", int'(irq), 0);
    rd(3, d); chk("R8 ien cleared", d & 1, 0);
    wr(3, 1);
    chk("R9 irq unmasked", int'(irq), 1);
    wr(5, 1);
    chk("R9 irq after flag clear", int'(irq), 0);
    rd(5, d); chk("R5 flag w1c", d, 0);
    // R4 N=0 acts as 1
    measure(0, 5, 1);
    // R6 sticky across a clean measurement
    measure(64, 3, 1);
    measure(2, 5, 0);
    rd(6, d); chk("R6 ovf sticky", (d >> 1) & 1, 1);
    wr(6, 2);
    rd(6, d); chk("R6 ovf w1c", (d >> 1) & 1, 0);
    // R7 start while busy
    msr_half = 5;
    wr(2, 64); wr(5, 1); wr(1, 1); wr(1, 1);
    wait_bit(5, 0, 1, 8000, ok); chk("R7 first done", int'(ok), 1);
    wr(5, 1);
    repeat (1200) @(negedge clk);
    rd(5, d); chk("R7 busy start no second done", d, 0);
    rd(6, d); chk("R7 busy start not busy", d & 1, 0);
    // R2 disable
    wr(0, 0);
    rd(7, d); chk("R2 sync pending on disable", d & 1, 1);
    wait_bit(7, 0, 0, 200, ok); chk("R2 sync clears on disable", int'(ok), 1);
    rd(0, d); chk("R2 ctrl reads 0", d, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule